// File: doc/BRIEF.md
# Resumable Address-Range Cache Maintenance Sequencer

This block executes one cache maintenance command that covers a variable byte range. The command gives the top address of the range and a byte count. It breaks the range into cache-line requests and hands them, one at a time, to a cache controller through a valid/ready request port. Each request then waits for a single response. The line size is a build parameter and is never visible to software. Every request carries the command's virtual/physical select and its operation code unchanged.

The count operand works as a read/write register. The top address is never changed. Lines are therefore handled from the bottom of the range upward, so the bytes that remain always form a range that ends at the same top address. The block ends a command in one of three ways:

- The whole range is done.
- A response reports a fault.
- An interrupt request is seen between two lines.

In every case it reports the number of untouched bytes, which is the value software writes back to the count register. Reissuing the command with the same top address and that count resumes the work exactly where it stopped.

Top module: `cmo_range_seq`

## Requirements
- R1: `cmd_ready_o` is high only while the block is idle. A command is taken on a clock edge where `cmd_valid_i` and `cmd_ready_o` are both high. No line request is raised while `cmd_ready_o` is high.
- R2: The first line request targets the line that holds address `hi - nbytes + 1`, aligned down to `LINE_BYTES`. Each following request targets the next line up, `LINE_BYTES` higher. Request addresses always have their low log2(`LINE_BYTES`) bits at zero.
- R3: The remaining count drops by the bytes from the current address to the end of its line after each successful response. For the first line this is the bytes from an unaligned start up to the boundary; after that it is a full line. The count saturates at zero. The command ends with `done_nbytes_o` = 0 and both stop flags low once the count reaches zero.
- R4: A command with `nbytes` = 0 raises no line request. It gives a done pulse with `done_nbytes_o` = 0 on the cycle after it is taken.
- R5: A response with `line_rsp_fault_i` high ends the command without counting that line. The done pulse has `done_fault_o` = 1, `done_irq_o` = 0, and `done_nbytes_o` equal to the count before that line.
- R6: `irq_i` is sampled only in the idle gap cycle before each line request, and before the first one. If it is high there, the command ends without a request. The done pulse has `done_irq_o` = 1 and `done_nbytes_o` equal to the current count. While a request is pending or awaiting its response, `irq_i` has no effect on that line.
- R7: While `line_req_valid_o` is high and `line_req_ready_i` is low, the request stays valid and its address, select and op code hold steady.
- R8: Every line request carries the `cmd_phys_i` (0 = virtual, 1 = physical) and `cmd_op_i` values captured when the command was taken.
- R9: `done_valid_o` is a single-cycle pulse, one per command. The block is idle and ready again on the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command offered |
| cmd_ready_o | output | 1 | Idle, command can be taken |
| cmd_hi_addr_i | input | XLEN | Highest byte address of the range |
| cmd_nbytes_i | input | XLEN | Bytes to process (count register value) |
| cmd_phys_i | input | 1 | Address kind: 0 virtual, 1 physical |
| cmd_op_i | input | OP_W | Maintenance operation code |
| irq_i | input | 1 | Interrupt request, honoured between lines |
| line_req_valid_o | output | 1 | Line request valid |
| line_req_ready_i | input | 1 | Cache accepts the request |
| line_req_addr_o | output | XLEN | Line-aligned request address |
| line_req_phys_o | output | 1 | Address kind for the request |
| line_req_op_o | output | OP_W | Operation code for the request |
| line_rsp_valid_i | input | 1 | Response for the pending line |
| line_rsp_fault_i | input | 1 | Response reports a fault |
| done_valid_o | output | 1 | Command finished, one-cycle pulse |
| done_nbytes_o | output | XLEN | Bytes left unprocessed, for write-back |
| done_fault_o | output | 1 | Command stopped by a fault |
| done_irq_o | output | 1 | Command stopped by an interrupt |

## Verification
All timing below is counted from the edge that takes the command, or from the edge that samples a line response:

- **Gap cycle.** The block spends the next cycle in its gap state. The next line request becomes visible one edge later, or the done pulse does if `irq_i` was high in the gap. A zero-count command instead shows its done pulse straight after the taking edge.
- **Handshake and response.** `line_req_valid_o` falls right after the ready edge. The done pulse, or the next gap, follows the edge that samples the response. The pulse is gone one edge after that.

The bench drives each input half a period before the edge that must sample it. It checks every output on the falling edge that follows that rising edge, and walks the protocol one edge at a time. Expected line addresses and remaining counts come from a small arithmetic model of the range in the bench.

// File: rtl/cmo_seq_pkg.sv
package cmo_seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_GAP   = 3'd1,
    ST_ISSUE = 3'd2,
    ST_WAIT  = 3'd3,
    ST_DONE  = 3'd4
  } seq_state_e;
endpackage

// File: rtl/cmo_step_calc.sv
module cmo_step_calc #(
  parameter int XLEN       = 32,
  parameter int LINE_BYTES = 64
) (
  input  logic [XLEN-1:0] cur_addr_i,
  input  logic [XLEN-1:0] left_i,
  output logic [XLEN-1:0] left_next_o,
  output logic [XLEN-1:0] next_addr_o,
  output logic [XLEN-1:0] line_addr_o,
  output logic            last_o
);
  localparam int OFF_W  = $clog2(LINE_BYTES);
  localparam int IDX_W  = XLEN - OFF_W;
  localparam logic [XLEN-1:0] LINE_SZ = XLEN'(LINE_BYTES);

  logic [XLEN-1:0]  off_ext;
  logic [XLEN-1:0]  step;
  logic [IDX_W-1:0] idx_inc;

  assign off_ext = {{IDX_W{1'b0}}, cur_addr_i[OFF_W-1:0]};
  // bytes from cursor to end of its line
  assign step    = LINE_SZ - off_ext;
  assign idx_inc = cur_addr_i[XLEN-1:OFF_W] + {{(IDX_W-1){1'b0}}, 1'b1};

  assign left_next_o = (left_i > step) ? (left_i - step) : '0;
  assign last_o      = (left_i <= step);
  assign next_addr_o = {idx_inc, {OFF_W{1'b0}}};
  assign line_addr_o = {cur_addr_i[XLEN-1:OFF_W], {OFF_W{1'b0}}};
endmodule

// File: rtl/cmo_seq_fsm.sv
module cmo_seq_fsm
  import cmo_seq_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cmd_fire_i,
  input  logic cmd_zero_i,
  input  logic irq_i,
  input  logic req_ready_i,
  input  logic rsp_valid_i,
  input  logic rsp_fault_i,
  input  logic last_i,
  output logic idle_o,
  output logic req_valid_o,
  output logic advance_o,
  output logic done_o,
  output logic fault_o,
  output logic irq_o
);
  seq_state_e state_q, state_d;
  logic fault_q, irq_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (cmd_fire_i) state_d = cmd_zero_i ? ST_DONE : ST_GAP;
      ST_GAP:   state_d = irq_i ? ST_DONE : ST_ISSUE;
      ST_ISSUE: if (req_ready_i) state_d = ST_WAIT;
      ST_WAIT:  if (rsp_valid_i) state_d = (rsp_fault_i || last_i) ? ST_DONE : ST_GAP;
      ST_DONE:  state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      fault_q <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      if (cmd_fire_i) begin
        fault_q <= 1'b0;
        irq_q   <= 1'b0;
      end else begin
        if (state_q == ST_GAP && irq_i) irq_q <= 1'b1;
        if (state_q == ST_WAIT && rsp_valid_i && rsp_fault_i) fault_q <= 1'b1;
      end
    end
  end

  assign idle_o      = (state_q == ST_IDLE);
  assign req_valid_o = (state_q == ST_ISSUE);
  assign advance_o   = (state_q == ST_WAIT) && rsp_valid_i && !rsp_fault_i;
  assign done_o      = (state_q == ST_DONE);
  assign fault_o     = fault_q;
  assign irq_o       = irq_q;
endmodule

// File: rtl/cmo_range_seq.sv
module cmo_range_seq #(
  parameter int XLEN       = 32,
  parameter int LINE_BYTES = 64,
  parameter int OP_W       = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            cmd_valid_i,
  output logic            cmd_ready_o,
  input  logic [XLEN-1:0] cmd_hi_addr_i,
  input  logic [XLEN-1:0] cmd_nbytes_i,
  input  logic            cmd_phys_i,
  input  logic [OP_W-1:0] cmd_op_i,
  input  logic            irq_i,
  output logic            line_req_valid_o,
  input  logic            line_req_ready_i,
  output logic [XLEN-1:0] line_req_addr_o,
  output logic            line_req_phys_o,
  output logic [OP_W-1:0] line_req_op_o,
  input  logic            line_rsp_valid_i,
  input  logic            line_rsp_fault_i,
  output logic            done_valid_o,
  output logic [XLEN-1:0] done_nbytes_o,
  output logic            done_fault_o,
  output logic            done_irq_o
);
  logic [XLEN-1:0] cur_addr_q, left_q, lo_addr;
  logic [XLEN-1:0] left_next, next_addr, line_addr;
  logic            phys_q, last, idle, advance, cmd_fire;
  logic [OP_W-1:0] op_q;

  assign cmd_fire = cmd_valid_i && idle;
  assign lo_addr  = cmd_hi_addr_i - cmd_nbytes_i + {{(XLEN-1){1'b0}}, 1'b1};

  cmo_step_calc #(.XLEN(XLEN), .LINE_BYTES(LINE_BYTES)) u_step (
    .cur_addr_i  (cur_addr_q),
    .left_i      (left_q),
    .left_next_o (left_next),
    .next_addr_o (next_addr),
    .line_addr_o (line_addr),
    .last_o      (last)
  );

  cmo_seq_fsm u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cmd_fire_i  (cmd_fire),
    .cmd_zero_i  (cmd_nbytes_i == '0),
    .irq_i       (irq_i),
    .req_ready_i (line_req_ready_i),
    .rsp_valid_i (line_rsp_valid_i),
    .rsp_fault_i (line_rsp_fault_i),
    .last_i      (last),
    .idle_o      (idle),
    .req_valid_o (line_req_valid_o),
    .advance_o   (advance),
    .done_o      (done_valid_o),
    .fault_o     (done_fault_o),
    .irq_o       (done_irq_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_addr_q <= '0;
      left_q     <= '0;
      phys_q     <= 1'b0;
      op_q       <= '0;
    end else if (cmd_fire) begin
      cur_addr_q <= lo_addr;
      left_q     <= cmd_nbytes_i;
      phys_q     <= cmd_phys_i;
      op_q       <= cmd_op_i;
    end else if (advance) begin
      cur_addr_q <= next_addr;
      left_q     <= left_next;
    end
  end

  assign cmd_ready_o     = idle;
  assign line_req_addr_o = line_addr;
  assign line_req_phys_o = phys_q;
  assign line_req_op_o   = op_q;
  assign done_nbytes_o   = left_q;
endmodule

// File: rtl/cmo_range_seq_chk.sv
module cmo_range_seq_chk #(
  parameter int XLEN       = 32,
  parameter int LINE_BYTES = 64,
  parameter int OP_W       = 4
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            cmd_valid_i,
  input logic            cmd_ready_o,
  input logic [XLEN-1:0] cmd_nbytes_i,
  input logic            irq_i,
  input logic            line_req_valid_o,
  input logic            line_req_ready_i,
  input logic [XLEN-1:0] line_req_addr_o,
  input logic            line_req_phys_o,
  input logic [OP_W-1:0] line_req_op_o,
  input logic            line_rsp_valid_i,
  input logic            line_rsp_fault_i,
  input logic            done_valid_o,
  input logic [XLEN-1:0] done_nbytes_o,
  input logic            done_fault_o,
  input logic            done_irq_o
);
  localparam int OFF_W = $clog2(LINE_BYTES);

  // R1
  idle_no_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_ready_o |-> !line_req_valid_o);

  // R2
  line_align_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    line_req_valid_o |-> (line_req_addr_o[OFF_W-1:0] == '0));

  // R4
  zero_cmd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && cmd_ready_o && cmd_nbytes_i == '0) |=> (done_valid_o && done_nbytes_o == '0));

  // R5
  fault_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_valid_o && done_fault_o) |-> ($past(line_rsp_valid_i && line_rsp_fault_i) && !done_irq_o));

  // R6
  irq_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_valid_o && done_irq_o) |-> ($past(irq_i) && !$past(line_req_valid_o) && !$past(line_rsp_valid_i)));

  // R7
  req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (line_req_valid_o && !line_req_ready_i) |=>
      (line_req_valid_o && $stable(line_req_addr_o) && $stable(line_req_phys_o) && $stable(line_req_op_o)));

  // R9
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_valid_o |=> (!done_valid_o && cmd_ready_o));
endmodule

bind cmo_range_seq cmo_range_seq_chk #(
  .XLEN(XLEN), .LINE_BYTES(LINE_BYTES), .OP_W(OP_W)
) u_chk (
  .clk_i            (clk_i),
  .rst_ni           (rst_ni),
  .cmd_valid_i      (cmd_valid_i),
  .cmd_ready_o      (cmd_ready_o),
  .cmd_nbytes_i     (cmd_nbytes_i),
  .irq_i            (irq_i),
  .line_req_valid_o (line_req_valid_o),
  .line_req_ready_i (line_req_ready_i),
  .line_req_addr_o  (line_req_addr_o),
  .line_req_phys_o  (line_req_phys_o),
  .line_req_op_o    (line_req_op_o),
  .line_rsp_valid_i (line_rsp_valid_i),
  .line_rsp_fault_i (line_rsp_fault_i),
  .done_valid_o     (done_valid_o),
  .done_nbytes_o    (done_nbytes_o),
  .done_fault_o     (done_fault_o),
  .done_irq_o       (done_irq_o)
);

// File: tb/sim_cmo_range_seq.sv
`timescale 1ns/1ps
module sim_cmo_range_seq;
  localparam int XLEN = 32;
  localparam int LB   = 64;
  localparam int OP_W = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0;
  logic cmd_ready;
  logic [XLEN-1:0] cmd_hi = '0, cmd_n = '0;
  logic cmd_phys = 1'b0;
  logic [OP_W-1:0] cmd_op = '0;
  logic irq = 1'b0;
  logic req_valid, req_phys;
  logic req_ready = 1'b0;
  logic [XLEN-1:0] req_addr;
  logic [OP_W-1:0] req_op;
  logic rsp_valid = 1'b0, rsp_fault = 1'b0;
  logic done_valid, done_fault, done_irq;
  logic [XLEN-1:0] done_n;

  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  cmo_range_seq #(.XLEN(XLEN), .LINE_BYTES(LB), .OP_W(OP_W)) u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .cmd_valid_i(cmd_valid), .cmd_ready_o(cmd_ready),
    .cmd_hi_addr_i(cmd_hi), .cmd_nbytes_i(cmd_n),
    .cmd_phys_i(cmd_phys), .cmd_op_i(cmd_op), .irq_i(irq),
    .line_req_valid_o(req_valid), .line_req_ready_i(req_ready),
    .line_req_addr_o(req_addr), .line_req_phys_o(req_phys), .line_req_op_o(req_op),
    .line_rsp_valid_i(rsp_valid), .line_rsp_fault_i(rsp_fault),
    .done_valid_o(done_valid), .done_nbytes_o(done_n),
    .done_fault_o(done_fault), .done_irq_o(done_irq)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [XLEN-1:0] act, input logic [XLEN-1:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  // one command; fault_idx/irq_idx/irq_issue_idx = -1 means none
  task automatic run_cmd(input logic [XLEN-1:0] hi, input logic [XLEN-1:0] n,
                         input logic phys, input logic [OP_W-1:0] op,
                         input int fault_idx, input int irq_idx,
                         input int irq_issue_idx, input int stall);
    logic [XLEN-1:0] cur, left, off, step;
    int idx;
    bit fin;
    chk(cmd_ready === 1'b1, "R1", "ready before command", {31'd0, cmd_ready}, 1);
    cmd_hi = hi; cmd_n = n; cmd_phys = phys; cmd_op = op; cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    chk(cmd_ready === 1'b0, "R1", "busy after accept", {31'd0, cmd_ready}, 0);
    if (n == 0) begin
      chk(done_valid === 1'b1 && req_valid === 1'b0, "R4", "zero count done", {31'd0, done_valid}, 1);
      chk(done_n === 0, "R4", "zero count write-back", done_n, 0);
    end else begin
      cur = hi - n + 1; left = n; idx = 0; fin = 0;
      while (!fin) begin
        if (idx == irq_idx) irq = 1'b1;
        if (irq) begin
          @(negedge clk);
          chk(done_valid === 1'b1 && done_irq === 1'b1 && done_fault === 1'b0 && req_valid === 1'b0,
              "R6", "irq stop flags", {29'd0, done_valid, done_irq, done_fault}, 32'h6);
          chk(done_n === left, "R6", "irq remaining", done_n, left);
          irq = 1'b0; fin = 1;
        end else begin
          @(negedge clk);
          chk(req_valid === 1'b1, "R2", "request raised", {31'd0, req_valid}, 1);
          chk(req_addr === (cur & ~(XLEN'(LB - 1))), "R2", "line address", req_addr, cur & ~(XLEN'(LB - 1)));
          chk(req_phys === phys && req_op === op, "R8", "select/op", {27'd0, req_phys, req_op}, {27'd0, phys, op});
          if (idx == irq_issue_idx) irq = 1'b1;
          for (int s = 0; s < stall; s++) begin
            @(negedge clk);
            chk(req_valid === 1'b1 && req_addr === (cur & ~(XLEN'(LB - 1))), "R7", "held under stall",
                req_addr, cur & ~(XLEN'(LB - 1)));
          end
          req_ready = 1'b1;
          @(negedge clk);
          req_ready = 1'b0;
          chk(req_valid === 1'b0 && done_valid === 1'b0, "R6", "pending line not cut",
              {30'd0, req_valid, done_valid}, 0);
          rsp_valid = 1'b1; rsp_fault = (idx == fault_idx);
          @(negedge clk);
          rsp_valid = 1'b0;
          if (rsp_fault) begin
            rsp_fault = 1'b0;
            chk(done_valid === 1'b1 && done_fault === 1'b1 && done_irq === 1'b0, "R5", "fault flags",
                {29'd0, done_valid, done_fault, done_irq}, 32'h6);
            chk(done_n === left, "R5", "fault remaining", done_n, left);
            fin = 1;
          end else begin
            off  = cur & XLEN'(LB - 1);
            step = XLEN'(LB) - off;
            left = (left > step) ? left - step : 0;
            cur  = cur - off + XLEN'(LB);
            if (left == 0) begin
              chk(done_valid === 1'b1 && done_fault === 1'b0 && done_irq === 1'b0, "R3", "normal end flags",
                  {29'd0, done_valid, done_fault, done_irq}, 32'h4);
              chk(done_n === 0, "R3", "normal end count", done_n, 0);
              fin = 1;
            end else begin
              chk(done_valid === 1'b0, "R3", "more lines pending", {31'd0, done_valid}, 0);
              idx++;
            end
          end
        end
      end
    end
    irq = 1'b0;
    @(negedge clk);
    chk(done_valid === 1'b0 && cmd_ready === 1'b1, "R9", "pulse ends, idle",
        {30'd0, done_valid, cmd_ready}, 1);
  endtask

  task automatic t_reset();
    chk(cmd_ready === 1'b1 && req_valid === 1'b0 && done_valid === 1'b0, "R1", "reset state",
        {29'd0, cmd_ready, req_valid, done_valid}, 32'h4);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    run_cmd(32'h0000_10FF, 32'h100, 1'b0, 4'h1, -1, -1, -1, 0); // R3 aligned, 4 lines
    run_cmd(32'h0000_2045, 32'h50,  1'b1, 4'h2, -1, -1, -1, 1); // R3 both ends unaligned
    run_cmd(32'h0000_0305, 32'h3,   1'b0, 4'h3, -1, -1, -1, 0); // R2 inside one line
    run_cmd(32'h0000_4000, 32'h0,   1'b0, 4'h4, -1, -1, -1, 0); // R4
    run_cmd(32'h0000_51FF, 32'h180, 1'b1, 4'h5,  1, -1, -1, 3); // R5 fault on 2nd line, R7 stall
    run_cmd(32'h0000_61FF, 32'h1F0, 1'b0, 4'h6, -1,  2, -1, 0); // R6 irq before 3rd line
    run_cmd(32'h0000_71FF, 32'h100, 1'b1, 4'h7, -1, -1,  1, 2); // R6 irq while pending
    run_cmd(32'h0000_80FF, 32'h80,  1'b0, 4'h8, -1,  0, -1, 0); // R6 irq before any line
    run_cmd(32'h0000_913F, 32'h40,  1'b0, 4'h9, -1, -1,  0, 0); // R6 irq pending on last line
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule